// File: doc/BRIEF.md
# Read/Write Turnaround Drain Controller

This block chooses which queue a DRAM command scheduler serves: the read queue or the write queue. It watches the occupancy of both queues and counts the write bursts issued in the current write phase. It drives a registered direction flag and a registered issue-enable. Reads are the default. The block turns to writes in two cases: when the write queue is close to full, or when no reads are waiting and writes have built up past a lower mark. Once it enters a write phase, it stays there until a minimum number of write bursts have been issued, unless the write queue runs dry first.

Each change of direction starts a bus turnaround window, during which issue-enable is held low. The window has its own length for each direction: one for read-to-write and one for write-to-read. The direction cannot change while a window is open.

Both marks are given as percentages of the write-queue depth. At elaboration they become whole entry counts, rounded up. With 64 entries, 85 % gives 55 and 50 % gives 32.

Top module: `rwt_dir_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the direction is read (`dir_write` = 0) and `issue_en` = 1.
- R2: In read mode with no turnaround pending, a write-queue level at or above the high mark, ceil(depth·HI_PCT/100), switches the direction to write at the next clock edge, even when reads are waiting.
- R3: In read mode with no turnaround pending, an empty read queue and a nonzero write-queue level at or above the low mark, ceil(depth·LO_PCT/100), switch the direction to write. A level below the low mark never causes a switch, and a level below the high mark never causes a switch while reads are waiting.
- R4: In write mode, with reads waiting and the write level below the high mark, the direction returns to read only at the edge after MIN_WR counted write bursts.
- R5: In write mode with no turnaround pending, an empty write queue returns the direction to read at the next edge, whatever the burst count.
- R6: In write mode, when the minimum count has been met but the write level is at or above the high mark, the direction stays write.
- R7: The burst count restarts from zero on every entry into write mode.
- R8: After a switch from read to write, `issue_en` is low for exactly T_RTW cycles. After a switch from write to read, it is low for exactly T_WTR cycles.
- R9: The direction does not change while `issue_en` is low.
- R10: A pulse on `wr_burst_done` counts only while in write mode with `issue_en` high. Pulses in read mode, or during a turnaround, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdq_level | input | $clog2(RQ_DEPTH+1) | Read-queue occupancy |
| wrq_level | input | $clog2(WQ_DEPTH+1) | Write-queue occupancy |
| wr_burst_done | input | 1 | One write burst issued this cycle |
| dir_write | output | 1 | 1 = serving writes, 0 = serving reads |
| issue_en | output | 1 | Commands may be issued (no turnaround pending) |

## Verification
The hardest case to reach is the exit from a write phase. It depends on three things at once: how many bursts were counted, which of those pulses landed inside the turnaround window or during read mode, and whether the write level sits at or above the high mark. The bench reaches it by holding `wr_burst_done` high across the whole read-to-write transition. It then counts the cycles until the direction returns, and that count must equal T_RTW + MIN_WR + 1. The threshold boundaries are covered by a sweep over every write level, for empty, partly filled and full read queues.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  // Round-up percentage of a depth, evaluated at elaboration
  function automatic int ceil_pct(input int depth, input int pct);
    return (depth * pct + 99) / 100;
  endfunction
endpackage

// File: rtl/rwt_phase_cnt.sv
module rwt_phase_cnt #(
  parameter int MIN_WR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic min_met
);
  localparam int CW = $clog2(MIN_WR + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_WR);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (inc && cnt_q < LIM)
      cnt_q <= cnt_q + 1'b1;
  end

  assign min_met = (cnt_q >= LIM);
endmodule

// File: rtl/rwt_turn_timer.sv
module rwt_turn_timer #(
  parameter int T_RTW = 2,
  parameter int T_WTR = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_to_wr,
  input  logic sw_to_rd,
  output logic busy,
  output logic issue_en
);
  localparam int TMAX = (T_RTW > T_WTR) ? T_RTW : T_WTR;
  localparam int TW = $clog2(TMAX + 1) < 1 ? 1 : $clog2(TMAX + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          en_q;

  always_comb begin
    if (sw_to_wr)      cnt_d = TW'(T_RTW);
    else if (sw_to_rd) cnt_d = TW'(T_WTR);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else               cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= (cnt_d == '0);
    end
  end

  assign busy     = (cnt_q != '0);
  assign issue_en = en_q;
endmodule

// File: rtl/rwt_dir_fsm.sv
module rwt_dir_fsm #(
  parameter int WQ_W   = 7,
  parameter int RQ_W   = 6,
  parameter int HI_THR = 55,
  parameter int LO_THR = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RQ_W-1:0] rdq_level,
  input  logic [WQ_W-1:0] wrq_level,
  input  logic            hold,
  input  logic            min_met,
  output logic            dir_write,
  output logic            sw_to_wr,
  output logic            sw_to_rd
);
  localparam logic [WQ_W-1:0] HI_V = WQ_W'(HI_THR);
  localparam logic [WQ_W-1:0] LO_V = WQ_W'(LO_THR);

  logic dir_q;
  logic wq_empty, rq_empty, wq_high;

  assign wq_empty = (wrq_level == '0);
  assign rq_empty = (rdq_level == '0);
  assign wq_high  = (wrq_level >= HI_V);

  always_comb begin
    sw_to_wr = 1'b0;
    sw_to_rd = 1'b0;
    if (!hold) begin
      if (!dir_q)
        sw_to_wr = wq_high || (rq_empty && !wq_empty && wrq_level >= LO_V);
      else
        sw_to_rd = wq_empty || (min_met && !rq_empty && !wq_high);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           dir_q <= 1'b0;
    else if (sw_to_wr) dir_q <= 1'b1;
    else if (sw_to_rd) dir_q <= 1'b0;
  end

  assign dir_write = dir_q;
endmodule

// File: rtl/rwt_dir_ctrl.sv
module rwt_dir_ctrl #(
  parameter int WQ_DEPTH = 64,
  parameter int RQ_DEPTH = 32,
  parameter int HI_PCT   = 85,
  parameter int LO_PCT   = 50,
  parameter int MIN_WR   = 16,
  parameter int T_RTW    = 2,
  parameter int T_WTR    = 6,
  localparam int WQ_W    = $clog2(WQ_DEPTH + 1),
  localparam int RQ_W    = $clog2(RQ_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RQ_W-1:0] rdq_level,
  input  logic [WQ_W-1:0] wrq_level,
  input  logic            wr_burst_done,
  output logic            dir_write,
  output logic            issue_en
);
  localparam int HI_THR = rwt_pkg::ceil_pct(WQ_DEPTH, HI_PCT);
  localparam int LO_THR = rwt_pkg::ceil_pct(WQ_DEPTH, LO_PCT);

  logic busy, min_met, sw_to_wr, sw_to_rd, cnt_inc;

  assign cnt_inc = dir_write && issue_en && wr_burst_done;

  rwt_dir_fsm #(
    .WQ_W(WQ_W), .RQ_W(RQ_W), .HI_THR(HI_THR), .LO_THR(LO_THR)
  ) fsm_i (
    .clk(clk), .rst(rst), .rdq_level(rdq_level), .wrq_level(wrq_level),
    .hold(busy), .min_met(min_met), .dir_write(dir_write),
    .sw_to_wr(sw_to_wr), .sw_to_rd(sw_to_rd)
  );

  rwt_phase_cnt #(.MIN_WR(MIN_WR)) cnt_i (
    .clk(clk), .rst(rst), .clear(sw_to_wr), .inc(cnt_inc), .min_met(min_met)
  );

  rwt_turn_timer #(.T_RTW(T_RTW), .T_WTR(T_WTR)) tmr_i (
    .clk(clk), .rst(rst), .sw_to_wr(sw_to_wr), .sw_to_rd(sw_to_rd),
    .busy(busy), .issue_en(issue_en)
  );
endmodule

// File: rtl/rwt_dir_chk.sv
module rwt_dir_chk #(
  parameter int WQ_W   = 7,
  parameter int RQ_W   = 6,
  parameter int HI_THR = 55,
  parameter int LO_THR = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [RQ_W-1:0] rdq_level,
  input logic [WQ_W-1:0] wrq_level,
  input logic            dir_write,
  input logic            issue_en
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!dir_write && issue_en)); // R1
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!dir_write && issue_en && wrq_level >= WQ_W'(HI_THR)) |=> dir_write); // R2
  AST_STAY_READ_LOW: assert property (@(posedge clk) disable iff (rst)
    (!dir_write && wrq_level < WQ_W'(LO_THR)) |=> !dir_write); // R3
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (dir_write && issue_en && wrq_level == '0) |=> !dir_write); // R5
  AST_GAP_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(dir_write) |-> !issue_en); // R8
  AST_GAP_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(dir_write) |-> !issue_en); // R8
  AST_HOLD_IN_TURN: assert property (@(posedge clk) disable iff (rst)
    !issue_en |=> $stable(dir_write)); // R9
endmodule

bind rwt_dir_ctrl rwt_dir_chk #(
  .WQ_W(WQ_W), .RQ_W(RQ_W), .HI_THR(HI_THR), .LO_THR(LO_THR)
) chk_i (
  .clk(clk), .rst(rst), .rdq_level(rdq_level), .wrq_level(wrq_level),
  .dir_write(dir_write), .issue_en(issue_en)
);

// File: tb/rwt_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module rwt_dir_ctrl_tb_top;
  localparam int D = 16, RQD = 8, HP = 85, LP = 50, MW = 4, TRW = 2, TWR = 3;
  localparam int HI = (D * HP + 99) / 100;   // 14
  localparam int LO = (D * LP + 99) / 100;   // 8
  localparam int WW = $clog2(D + 1), RW = $clog2(RQD + 1);

  logic clk = 0, rst = 1, wr_burst_done = 0, dir_write, issue_en;
  logic [RW-1:0] rdq_level = '0;
  logic [WW-1:0] wrq_level = '0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rwt_dir_ctrl #(.WQ_DEPTH(D), .RQ_DEPTH(RQD), .HI_PCT(HP), .LO_PCT(LP),
                 .MIN_WR(MW), .T_RTW(TRW), .T_WTR(TWR)) dut_i (
    .clk(clk), .rst(rst), .rdq_level(rdq_level), .wrq_level(wrq_level),
    .wr_burst_done(wr_burst_done), .dir_write(dir_write), .issue_en(issue_en));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    wr_burst_done = 0; rdq_level = 1; wrq_level = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic enter_write();
    rdq_level = 3; wrq_level = WW'(HI);
    @(negedge clk);
    chk("R2 entry", int'(dir_write), 1);
  endtask

  initial begin
    int n, lows, expd;
    repeat (3) @(negedge clk);
    chk("R1 dir in reset", int'(dir_write), 0);
    chk("R1 issue_en in reset", int'(issue_en), 1);
    rst = 0;
    @(negedge clk);
    chk("R1 dir after reset", int'(dir_write), 0);
    chk("R1 issue_en after reset", int'(issue_en), 1);

    // Threshold sweep from idle read mode
    for (int ri = 0; ri < 3; ri++) begin
      for (int w = 0; w <= D; w++) begin
        go_idle();
        rdq_level = (ri == 0) ? RW'(0) : (ri == 1) ? RW'(1) : RW'(RQD);
        wrq_level = WW'(w);
        @(negedge clk);
        expd = ((w >= HI) || (ri == 0 && w >= LO && w != 0)) ? 1 : 0;
        chk((w >= HI) ? "R2 sweep" : "R3 sweep", int'(dir_write), expd);
      end
    end

    // R10: pulses in read mode and during turnaround are not counted
    go_idle();
    rdq_level = 3; wr_burst_done = 1;
    repeat (5) @(negedge clk);
    enter_write();
    wrq_level = 10;
    lows = issue_en ? 0 : 1;
    n = 0;
    while (dir_write && n < 100) begin
      @(negedge clk); n++;
      if (dir_write && !issue_en) lows++;
    end
    chk("R10 cycles to return", n, TRW + MW + 1);
    chk("R8 read-to-write gap", lows, TRW);
    wr_burst_done = 0;
    n = 0;
    while (!issue_en && n < 100) begin n++; @(negedge clk); end
    chk("R8 write-to-read gap", n, TWR);

    // R7 / R4: second phase needs the full minimum again
    go_idle();
    enter_write();
    wrq_level = 10;
    repeat (12) @(negedge clk);
    chk("R7 no bursts keeps write", int'(dir_write), 1);
    wr_burst_done = 1;
    repeat (MW) @(negedge clk);
    chk("R4 held until minimum", int'(dir_write), 1);
    wr_burst_done = 0;
    @(negedge clk);
    chk("R4 return after minimum", int'(dir_write), 0);

    // R6: minimum met but still at high mark
    go_idle();
    enter_write();
    repeat (3) @(negedge clk);
    wr_burst_done = 1;
    repeat (MW) @(negedge clk);
    wr_burst_done = 0;
    repeat (5) @(negedge clk);
    chk("R6 stays write at high mark", int'(dir_write), 1);
    wrq_level = WW'(HI - 1);
    @(negedge clk);
    chk("R6 returns below high mark", int'(dir_write), 0);

    // R5: empty write queue ends phase early
    go_idle();
    enter_write();
    repeat (TRW) @(negedge clk);
    wrq_level = 0;
    @(negedge clk);
    chk("R5 early exit on empty", int'(dir_write), 0);

    // R9: no direction change inside turnaround
    go_idle();
    enter_write();
    wrq_level = 0;
    n = 0;
    while (dir_write && n < 100) begin @(negedge clk); n++; end
    chk("R9 held through turnaround", n, TRW + 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule